// File: doc/BRIEF.md
# Pulse-Interval Reader-to-Tag Frame Encoder

This block turns a stream of payload bits into the single modulation-enable waveform of one reader-to-tag frame coded by pulse-interval encoding. Every duration is counted in ticks of 0.1 µs, taken from a `tick` strobe. A frame opens with a fixed low delimiter. Then comes the frame-sync: a data-0 symbol and an RTcal symbol. A query frame also carries a TRcal symbol, which makes the full preamble. The payload symbols follow, and then a CRC-5 or a CRC-16 that the block computes while the bits stream past.

Each symbol is a carrier-on (high) interval followed by a modulated (low) pulse of fixed width. The host picks Tari, the pulse width as a fraction of Tari, the data-1 length as a multiple of Tari, the CRC kind, the TRcal count and the query flag, and then pulses `start`. Payload bits arrive on a valid/ready stream. The block holds one bit ahead of the symbol being sent. `in_ready` is only high during a frame, while that one-bit slot is empty and the bit marked last has not yet been taken. A source may hold `in_valid` low at any time. If the next bit is not there when a symbol ends, the carrier is held on until the bit arrives. When the frame is complete, the block releases the carrier and pulses `done`.

Top module: `pie_tx_encoder`

## Requirements
- R1: A `start` pulse while idle sets `mod_on` to 1 from the next cycle on, for a delimiter of 125 ticks.
- R2: `cfg_tari` 0, 1, 2 and 3 give Tari of 63, 125, 250 and 250 ticks. A data-0 symbol is high for Tari minus PW, then low for PW.
- R3: PW is (Tari·p+50)/100 ticks, rounded down, with p = 27, 35, 44 or 50 for `cfg_pw` 0 to 3.
- R4: The data-1 length D1 is (Tari·q+50)/100 ticks, rounded down, with q = 150, 166, 183 or 200 for `cfg_one` 0 to 3. A data-1 symbol is high for D1 minus PW, then low for PW.
- R5: After the delimiter come a data-0 symbol and then an RTcal symbol of length Tari+D1. When `cfg_query` is 1, a TRcal symbol of `cfg_trcal`+1 ticks follows. The payload symbols come next. The TRcal length must exceed PW.
- R6: A bit is transferred at a clock edge where `in_valid` and `in_ready` are both 1. `in_last` marks the final bit, and a frame carries at least one bit. If no bit is waiting when a symbol ends, `mod_on` stays 0 until one arrives, and the next symbol starts then.
- R7: With `cfg_crc5`=0, the block appends 16 symbols for CRC-16 (polynomial 0x1021, preset 0xFFFF), complemented and MSB first. With `cfg_crc5`=1, it appends 5 symbols for CRC-5 (polynomial 0x09, preset 01001b), not complemented and MSB first. The CRC covers the payload bits only.
- R8: In the cycle after the last CRC pulse, `mod_on` is 0 and `done` is 1 for one cycle. `busy` is 1 from the cycle after `start` through the `done` cycle, and 0 after it.
- R9: Only cycles with `tick`=1 count toward a duration. While `tick` is 0, the waveform is frozen.
- R10: A `start` pulse during a frame has no effect on the waveform.
- R11: In reset, `mod_on`, `done`, `busy` and `in_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 0.1 µs time-base strobe |
| start | input | 1 | Begins a frame while idle |
| cfg_tari | input | 2 | Tari select |
| cfg_pw | input | 2 | Low-pulse width select |
| cfg_one | input | 2 | Data-1 length select |
| cfg_crc5 | input | 1 | 1 selects CRC-5, 0 selects CRC-16 |
| cfg_query | input | 1 | 1 adds the TRcal symbol |
| cfg_trcal | input | 12 | TRcal length minus one, in ticks |
| in_valid | input | 1 | Payload bit valid |
| in_ready | output | 1 | Encoder can take a bit |
| in_bit | input | 1 | Payload bit |
| in_last | input | 1 | Marks the final payload bit |
| mod_on | output | 1 | 1 = modulation on (carrier low) |
| done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Frame in progress |

## Verification
The bench records every high and low run of `mod_on` and compares it against the run list computed from the selected Tari, fractions, payload and CRC. A wrong rounding or fraction table shows up as a pulse or data-1 run that is one or more ticks off. A wrong CRC preset, complement or bit order turns data-0 runs into data-1 runs in the tail. A missing or misplaced TRcal shifts the run count.

Directed corner cases cover the following. A tick pause inside the delimiter must stretch that run by exactly the pause. A starved stream must lengthen only the first payload high run. A stray `start` mid-frame must leave the run list unchanged. A one-bit CRC-5 frame tests the shortest tail. Finally, `done` must line up with the first carrier-on cycle and be followed by `busy` low.

// File: rtl/pie_tx_pkg.sv
package pie_tx_pkg;

  typedef enum logic [2:0] {PH_IDLE, PH_DELIM, PH_WAIT, PH_HI, PH_LO, PH_END} phase_e;
  typedef enum logic [2:0] {SK_D0, SK_RT, SK_TR, SK_DAT, SK_CRC} sym_e;

  localparam logic [15:0] CRC16_POLY = 16'h1021;
  localparam logic [15:0] CRC16_INIT = 16'hFFFF;
  localparam logic [4:0]  CRC5_POLY  = 5'b01001;
  localparam logic [4:0]  CRC5_INIT  = 5'b01001;

  // low-pulse width as percent of Tari
  function automatic int unsigned pw_pct(input logic [1:0] s);
    case (s)
      2'd0:    return 27;
      2'd1:    return 35;
      2'd2:    return 44;
      default: return 50;
    endcase
  endfunction

  // data-1 length as percent of Tari
  function automatic int unsigned one_pct(input logic [1:0] s);
    case (s)
      2'd0:    return 150;
      2'd1:    return 166;
      2'd2:    return 183;
      default: return 200;
    endcase
  endfunction

  function automatic int unsigned scale_pct(input int unsigned base, input int unsigned pct);
    return (base * pct + 50) / 100;
  endfunction

endpackage

// File: rtl/pie_len_calc.sv
module pie_len_calc
  import pie_tx_pkg::*;
#(
  parameter int LEN_W     = 13,
  parameter int TRCAL_W   = 12,
  parameter int TARI_FAST = 63,
  parameter int TARI_MID  = 125,
  parameter int TARI_SLOW = 250
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [1:0]         tari_sel,
  input  logic [1:0]         pw_sel,
  input  logic [1:0]         one_sel,
  input  logic [TRCAL_W-1:0] trcal,
  output logic [LEN_W-1:0]   pw_len,
  output logic [LEN_W-1:0]   d0_hi,
  output logic [LEN_W-1:0]   d1_hi,
  output logic [LEN_W-1:0]   rt_hi,
  output logic [LEN_W-1:0]   tr_hi
);

  int unsigned tari_t, pw_t, one_t, tr_t;

  always_comb begin
    case (tari_sel)
      2'd0:    tari_t = TARI_FAST;
      2'd1:    tari_t = TARI_MID;
      default: tari_t = TARI_SLOW;
    endcase
    pw_t  = scale_pct(tari_t, pw_pct(pw_sel));
    one_t = scale_pct(tari_t, one_pct(one_sel));
    tr_t  = int'(trcal) + 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pw_len <= '0;
      d0_hi  <= '0;
      d1_hi  <= '0;
      rt_hi  <= '0;
      tr_hi  <= '0;
    end else if (load) begin
      pw_len <= LEN_W'(pw_t);
      d0_hi  <= LEN_W'(tari_t - pw_t);
      d1_hi  <= LEN_W'(one_t - pw_t);
      rt_hi  <= LEN_W'(tari_t + one_t - pw_t);
      tr_hi  <= LEN_W'(tr_t - pw_t);
    end
  end

  // R4: data-1 high time always exceeds data-0 high time
  a_r4_one_longer: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pw_len != '0) |-> (d1_hi > d0_hi));

  // R3: pulse never exceeds half of Tari (rounding allows one tick)
  a_r3_pw_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pw_len != '0) |-> (pw_len <= d0_hi + 1'b1));

endmodule

// File: rtl/pie_crc_gen.sv
module pie_crc_gen
  import pie_tx_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             mode5,
  input  logic             shift,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             crc_bit,
  output logic [SEL_W-1:0] crc_len
);

  logic [15:0] c16, c16_sh;
  logic [4:0]  c5, c5_sh;
  logic        m5;
  logic        fb16, fb5;

  assign fb16 = din ^ c16[15];
  assign fb5  = din ^ c5[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c16 <= CRC16_INIT;
      c5  <= CRC5_INIT;
      m5  <= 1'b0;
    end else if (init) begin
      c16 <= CRC16_INIT;
      c5  <= CRC5_INIT;
      m5  <= mode5;
    end else if (shift) begin
      c16 <= {c16[14:0], 1'b0} ^ (fb16 ? CRC16_POLY : 16'h0000);
      c5  <= {c5[3:0], 1'b0} ^ (fb5 ? CRC5_POLY : 5'b00000);
    end
  end

  assign c16_sh  = c16 << sel;
  assign c5_sh   = c5 << sel;
  assign crc_bit = m5 ? c5_sh[4] : ~c16_sh[15];
  assign crc_len = m5 ? SEL_W'(5) : SEL_W'(16);

endmodule

// File: rtl/pie_bit_buf.sv
module pie_bit_buf (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_last,
  output logic in_ready,
  input  logic take,
  output logic has_bit,
  output logic bit_q,
  output logic last_q
);

  logic got_last;

  assign in_ready = en && !has_bit && !got_last;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      has_bit  <= 1'b0;
      bit_q    <= 1'b0;
      last_q   <= 1'b0;
      got_last <= 1'b0;
    end else if (in_valid && in_ready) begin
      has_bit  <= 1'b1;
      bit_q    <= in_bit;
      last_q   <= in_last;
      got_last <= in_last;
    end else if (take) begin
      has_bit <= 1'b0;
    end
  end

  // R6: the sequencer only consumes a held bit
  a_r6_take_full: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> has_bit);

  // R6: a held bit stays put until consumed
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (has_bit && !take && !clear) |=> (has_bit && $stable(bit_q)));

endmodule

// File: rtl/pie_seq.sv
module pie_seq
  import pie_tx_pkg::*;
#(
  parameter int DELIM_TICKS = 125,
  parameter int LEN_W       = 13,
  parameter int SEL_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic             cfg_query,
  input  logic             has_bit,
  input  logic             buf_bit,
  input  logic             buf_last,
  input  logic [LEN_W-1:0] pw_len,
  input  logic [LEN_W-1:0] d0_hi,
  input  logic [LEN_W-1:0] d1_hi,
  input  logic [LEN_W-1:0] rt_hi,
  input  logic [LEN_W-1:0] tr_hi,
  input  logic             crc_bit,
  input  logic [SEL_W-1:0] crc_len,
  output logic             accept,
  output logic             take,
  output logic [SEL_W-1:0] crc_sel,
  output logic             mod_on,
  output logic             done,
  output logic             busy
);

  phase_e           phase, nphase;
  sym_e             kind, nkind;
  logic [LEN_W-1:0] cnt, ncnt;
  logic [SEL_W-1:0] idx, nidx;
  logic             cur_last, nlast, q_query, want_data, seg_end, timed;

  assign accept  = (phase == PH_IDLE) && start;
  assign timed   = (phase == PH_DELIM) || (phase == PH_HI) || (phase == PH_LO);
  assign seg_end = timed && tick && (cnt <= LEN_W'(1));
  assign crc_sel = (kind == SK_CRC) ? idx + 1'b1 : '0;

  always_comb begin
    nphase    = phase;
    nkind     = kind;
    nidx      = idx;
    nlast     = cur_last;
    ncnt      = (timed && tick && cnt > LEN_W'(1)) ? cnt - 1'b1 : cnt;
    want_data = 1'b0;
    take      = 1'b0;
    case (phase)
      PH_IDLE: if (start) begin
        nphase = PH_DELIM;
        ncnt   = LEN_W'(DELIM_TICKS);
      end
      PH_DELIM: if (seg_end) begin
        nphase = PH_HI;
        nkind  = SK_D0;
        ncnt   = d0_hi;
      end
      PH_HI: if (seg_end) begin
        nphase = PH_LO;
        ncnt   = pw_len;
      end
      PH_LO: if (seg_end) begin
        case (kind)
          SK_D0: begin
            nkind  = SK_RT;
            nphase = PH_HI;
            ncnt   = rt_hi;
          end
          SK_RT: if (q_query) begin
            nkind  = SK_TR;
            nphase = PH_HI;
            ncnt   = tr_hi;
          end else begin
            want_data = 1'b1;
          end
          SK_TR: want_data = 1'b1;
          SK_DAT: if (cur_last) begin
            nkind  = SK_CRC;
            nidx   = '0;
            nphase = PH_HI;
            ncnt   = crc_bit ? d1_hi : d0_hi;
          end else begin
            want_data = 1'b1;
          end
          SK_CRC: if (idx == crc_len - 1'b1) begin
            nphase = PH_END;
          end else begin
            nidx   = idx + 1'b1;
            nphase = PH_HI;
            ncnt   = crc_bit ? d1_hi : d0_hi;
          end
          default: nphase = PH_END;
        endcase
      end
      PH_WAIT: want_data = 1'b1;
      PH_END:  nphase = PH_IDLE;
      default: nphase = PH_IDLE;
    endcase
    if (want_data) begin
      nkind = SK_DAT;
      if (has_bit) begin
        take   = 1'b1;
        nlast  = buf_last;
        nphase = PH_HI;
        ncnt   = buf_bit ? d1_hi : d0_hi;
      end else begin
        nphase = PH_WAIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      kind     <= SK_D0;
      cnt      <= '0;
      idx      <= '0;
      cur_last <= 1'b0;
      q_query  <= 1'b0;
    end else begin
      phase    <= nphase;
      kind     <= nkind;
      cnt      <= ncnt;
      idx      <= nidx;
      cur_last <= nlast;
      if (accept) q_query <= cfg_query;
    end
  end

  assign mod_on = (phase == PH_DELIM) || (phase == PH_LO);
  assign done   = (phase == PH_END);
  assign busy   = (phase != PH_IDLE);

  // R1: an accepted start opens the delimiter at once
  a_r1_delim_open: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mod_on && busy));

  // R8: done lasts one cycle and returns the block to idle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R8: done follows directly on the final low pulse
  a_r8_done_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mod_on) && !mod_on));

  // R10: start during a frame does not end it
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

  // R9: a missing tick freezes the waveform
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (timed && !tick) |=> $stable(mod_on));

endmodule

// File: rtl/pie_tx_encoder.sv
module pie_tx_encoder
  import pie_tx_pkg::*;
#(
  parameter int DELIM_TICKS = 125,
  parameter int TRCAL_W     = 12,
  parameter int TARI_FAST   = 63,
  parameter int TARI_MID    = 125,
  parameter int TARI_SLOW   = 250
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic [1:0]         cfg_tari,
  input  logic [1:0]         cfg_pw,
  input  logic [1:0]         cfg_one,
  input  logic               cfg_crc5,
  input  logic               cfg_query,
  input  logic [TRCAL_W-1:0] cfg_trcal,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_bit,
  input  logic               in_last,
  output logic               mod_on,
  output logic               done,
  output logic               busy
);

  localparam int LEN_W = TRCAL_W + 1;
  localparam int SEL_W = 5;

  logic [LEN_W-1:0] pw_len, d0_hi, d1_hi, rt_hi, tr_hi;
  logic [SEL_W-1:0] crc_sel, crc_len;
  logic             accept, take, has_bit, buf_bit, buf_last, crc_bit;

  pie_len_calc #(
    .LEN_W(LEN_W), .TRCAL_W(TRCAL_W),
    .TARI_FAST(TARI_FAST), .TARI_MID(TARI_MID), .TARI_SLOW(TARI_SLOW)
  ) u_len (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .tari_sel(cfg_tari), .pw_sel(cfg_pw), .one_sel(cfg_one), .trcal(cfg_trcal),
    .pw_len(pw_len), .d0_hi(d0_hi), .d1_hi(d1_hi), .rt_hi(rt_hi), .tr_hi(tr_hi)
  );

  pie_bit_buf u_buf (
    .clk(clk), .rst_n(rst_n), .clear(accept), .en(busy),
    .in_valid(in_valid), .in_bit(in_bit), .in_last(in_last), .in_ready(in_ready),
    .take(take), .has_bit(has_bit), .bit_q(buf_bit), .last_q(buf_last)
  );

  pie_crc_gen #(.SEL_W(SEL_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(accept), .mode5(cfg_crc5),
    .shift(take), .din(buf_bit), .sel(crc_sel),
    .crc_bit(crc_bit), .crc_len(crc_len)
  );

  pie_seq #(.DELIM_TICKS(DELIM_TICKS), .LEN_W(LEN_W), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .cfg_query(cfg_query),
    .has_bit(has_bit), .buf_bit(buf_bit), .buf_last(buf_last),
    .pw_len(pw_len), .d0_hi(d0_hi), .d1_hi(d1_hi), .rt_hi(rt_hi), .tr_hi(tr_hi),
    .crc_bit(crc_bit), .crc_len(crc_len),
    .accept(accept), .take(take), .crc_sel(crc_sel),
    .mod_on(mod_on), .done(done), .busy(busy)
  );

endmodule

// File: tb/pie_tx_encoder_bench.sv
module pie_tx_encoder_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, tick = 1'b1, start = 1'b0;
  logic [1:0]  cfg_tari = '0, cfg_pw = '0, cfg_one = '0;
  logic        cfg_crc5 = 1'b0, cfg_query = 1'b0;
  logic [11:0] cfg_trcal = '0;
  logic        in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0;
  logic        in_ready, mod_on, done, busy;

  pie_tx_encoder u_pie_tx_encoder (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .cfg_tari(cfg_tari), .cfg_pw(cfg_pw), .cfg_one(cfg_one),
    .cfg_crc5(cfg_crc5), .cfg_query(cfg_query), .cfg_trcal(cfg_trcal),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_last(in_last),
    .mod_on(mod_on), .done(done), .busy(busy)
  );

  int errors = 0, checks = 0, cyc = 0;
  int exp_runs[128], exp_req[128], exp_n;
  int act_runs[128], act_n;
  logic bits[64];

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL R8 watchdog actual=%0d expected<=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic int b_tari(input logic [1:0] s);
    return (s == 2'd0) ? 63 : (s == 2'd1) ? 125 : 250;
  endfunction
  function automatic int b_pw(input int t, input logic [1:0] s);
    int p;
    p = (s == 0) ? 27 : (s == 1) ? 35 : (s == 2) ? 44 : 50;
    return (t * p + 50) / 100;
  endfunction
  function automatic int b_one(input int t, input logic [1:0] s);
    int q;
    q = (s == 0) ? 150 : (s == 1) ? 166 : (s == 2) ? 183 : 200;
    return (t * q + 50) / 100;
  endfunction

  task automatic push_exp(input int v, input int r);
    exp_runs[exp_n] = v;
    exp_req[exp_n]  = r;
    exp_n++;
  endtask

  // expected run list: even index = low (mod on), odd = high
  task automatic build_expected(input int nb);
    int t, pw, one, crcn;
    logic [15:0] c16;
    logic [4:0]  c5;
    logic        b;
    t = b_tari(cfg_tari); pw = b_pw(t, cfg_pw); one = b_one(t, cfg_one);
    exp_n = 0;
    push_exp(125, 1);                     // R1 delimiter
    push_exp(t - pw, 2); push_exp(pw, 3); // R2 data-0, R3 pulse
    push_exp(t + one - pw, 5); push_exp(pw, 3); // R5 RTcal
    if (cfg_query) begin
      push_exp(int'(cfg_trcal) + 1 - pw, 5); push_exp(pw, 3); // R5 TRcal
    end
    c16 = 16'hFFFF; c5 = 5'b01001;
    for (int i = 0; i < nb; i++) begin
      push_exp(bits[i] ? one - pw : t - pw, bits[i] ? 4 : 2); // R4 data-1
      push_exp(pw, 3);
      b = bits[i] ^ c16[15]; c16 = {c16[14:0], 1'b0}; if (b) c16 = c16 ^ 16'h1021;
      b = bits[i] ^ c5[4];   c5  = {c5[3:0], 1'b0};   if (b) c5  = c5 ^ 5'b01001;
    end
    crcn = cfg_crc5 ? 5 : 16;
    for (int k = 0; k < crcn; k++) begin // R7 CRC tail
      b = cfg_crc5 ? c5[4 - k] : ~c16[15 - k];
      push_exp(b ? one - pw : t - pw, 7);
      push_exp(pw, 3);
    end
  endtask

  task automatic run_frame(input int nb, input int pause_at, input int pause_len,
                           input bit starve, input bit extra_start);
    int c, idx, cur_len, first_dat;
    bit acc, cur_lvl, fin;
    for (int i = 0; i < nb; i++) bits[i] = 1'($urandom % 2);
    build_expected(nb);
    if (pause_len > 0) begin
      exp_runs[0] += pause_len; // R9 frozen delimiter
      exp_req[0] = 9;
    end
    first_dat = cfg_query ? 7 : 5;
    act_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    c = 0; idx = 0; acc = 0; cur_lvl = 1; cur_len = 0; fin = 0;
    while (!fin && c < 100000) begin
      if (acc) idx++;
      tick     = !(c >= pause_at && c < pause_at + pause_len);
      in_valid = (idx < nb) && !(starve && c < 600) && ($urandom % 4 != 0);
      in_bit   = (idx < nb) ? bits[idx] : 1'b0;
      in_last  = (idx == nb - 1);
      acc      = in_valid && in_ready;
      start    = extra_start && (c == 200); // R10 stray start
      if (done) begin
        check(!mod_on && cur_lvl, "R8", int'(mod_on), 0, "carrier state at done");
        act_runs[act_n] = cur_len; act_n++;
        fin = 1;
      end else if (mod_on == cur_lvl) begin
        cur_len++;
      end else begin
        if (act_n < 127) begin act_runs[act_n] = cur_len; act_n++; end
        cur_lvl = mod_on; cur_len = 1;
      end
      c++;
      @(negedge clk);
    end
    in_valid = 1'b0; tick = 1'b1; start = 1'b0;
    if (!fin) check(1'b0, "R8", c, 0, "frame timeout");
    check(!busy && !done, "R8", int'(busy), 0, "busy after done");
    check(idx == nb, "R6", idx, nb, "bits transferred");
    check(act_n == exp_n, "R5", act_n, exp_n, "run count");
    for (int i = 0; i < act_n && i < exp_n; i++) begin
      if (starve && i == first_dat)
        check(act_runs[i] > exp_runs[i], "R6", act_runs[i], exp_runs[i], "stretched high while starved");
      else
        check(act_runs[i] == exp_runs[i], $sformatf("R%0d", exp_req[i]), act_runs[i], exp_runs[i],
              $sformatf("run %0d", i));
    end
  endtask

  task automatic set_cfg(input logic [1:0] t, input logic [1:0] p, input logic [1:0] o,
                         input logic c5, input logic q, input logic [11:0] tr);
    cfg_tari = t; cfg_pw = p; cfg_one = o; cfg_crc5 = c5; cfg_query = q; cfg_trcal = tr;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R11 reset state
    check(!mod_on && !done && !busy && !in_ready, "R11",
          {mod_on, done, busy, in_ready}, 0, "outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R5 R7: slow Tari, query with TRcal, CRC-16
    set_cfg(2'd2, 2'd0, 2'd0, 1'b0, 1'b1, 12'h400);
    run_frame(3, -1, 0, 0, 0);
    // R3 R4 R7: widest pulse, longest data-1, single bit, CRC-5
    set_cfg(2'd1, 2'd3, 2'd3, 1'b1, 1'b0, 12'd0);
    run_frame(1, -1, 0, 0, 0);
    // R9: tick pause inside the delimiter
    set_cfg(2'd0, 2'd1, 2'd1, 1'b1, 1'b1, 12'd300);
    run_frame(6, 10, 37, 0, 0);
    // R10: start during frame; Tari select 3
    set_cfg(2'd3, 2'd2, 2'd2, 1'b0, 1'b0, 12'd0);
    run_frame(2, -1, 0, 0, 1);
    // R6: starved stream holds carrier
    set_cfg(2'd0, 2'd0, 2'd2, 1'b1, 1'b0, 12'd0);
    run_frame(4, -1, 0, 1, 0);
    // random frames
    for (int f = 0; f < 6; f++) begin
      set_cfg(2'($urandom % 3), 2'($urandom % 4), 2'($urandom % 4),
              1'($urandom % 2), 1'($urandom % 2), 12'(200 + $urandom % 1800));
      run_frame(1 + int'($urandom % 16), -1, 0, 0, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule